// File: doc/BRIEF.md
# Stride Prefetch Candidate Generator

This block turns one prefetch trigger into a short run of candidate prefetch addresses. A trigger carries the cache-line address of a demand access, a signed stride in lines and a degree. The block then walks the multiples of the stride, one multiple per clock cycle. Each candidate line is converted to a line-aligned byte address. The candidate is offered on a valid/ready output only when it falls in the same page as the triggering access. Candidates that leave the page are discarded without a trace, and the walk continues with the next multiple.

A stride-detection table upstream drives the trigger port. A prefetch queue downstream takes the candidates. While a run is in progress the trigger port is held not-ready, and it stays not-ready until the last candidate has left the output register. Runs from different triggers therefore never interleave.

Top module: `stride_pf_gen`

## Requirements
- R1: For a trigger with line address L, stride S and degree D, the block offers the candidates d = 1, 2, … D in increasing order of d. Candidate d is the line (L + S·d) modulo 2^LINE_W, shifted left by BLK_LOG2 bits, so its low BLK_LOG2 address bits are zero.
- R2: Every offered candidate has a priority field pf_prio equal to zero.
- R3: A candidate is offered only if its address bits [ADDR_W-1:PAGE_LOG2] equal those of the triggering address L << BLK_LOG2. Other candidates are dropped and do not stop the remaining multiples.
- R4: The stride is used exactly as given, with no rounding. A negative stride gives descending addresses, and a zero stride repeats the trigger's own line D times.
- R5: The degree is captured on the cycle the trigger is accepted. Later changes on trig_degree do not change the length of the run in progress.
- R6: After a trigger with a nonzero degree is accepted, trig_ready is low from the next cycle on. It stays low until every multiple has been evaluated and the output register is empty. A trigger held valid during a run is taken only after that run's candidates.
- R7: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_addr does not change. No candidate is lost or duplicated under backpressure.
- R8: A trigger with degree zero is accepted, produces no candidate, and leaves trig_ready high on the next cycle.
- R9: In the cycle after reset, pf_valid is low and trig_ready is high.
- R10: With pf_ready held high, each multiple takes one cycle whether or not it is dropped. trig_ready returns high D+1 clock edges after the accepting edge when the last candidate is kept, and D edges after it when the last candidate is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger present |
| trig_ready | output | 1 | Block can take a trigger |
| trig_line | input | ADDR_W-BLK_LOG2 | Cache-line address of the triggering access |
| trig_stride | input | STRIDE_W | Signed stride in cache lines |
| trig_degree | input | DEG_W | Number of multiples to walk |
| pf_valid | output | 1 | Candidate present |
| pf_ready | input | 1 | Consumer takes the candidate |
| pf_addr | output | ADDR_W | Line-aligned byte address of the candidate |
| pf_prio | output | PRIO_W | Candidate priority, always zero |

## Verification
The assertions assume that the consumer obeys valid/ready. They also assume that trig_line, trig_stride and trig_degree are stable during any cycle in which trig_valid is high with trig_ready high. The bench changes these inputs only at falling edges and changes the fields of a held trigger only while the trigger port is not ready. It drives pf_ready from one process that first records a transfer and then sets the next ready value, so a transfer is always seen with the ready level that completed it.

// File: rtl/spg_pkg.sv
package spg_pkg;
  parameter int unsigned SPG_ADDR_W    = 48;
  parameter int unsigned SPG_BLK_LOG2  = 6;
  parameter int unsigned SPG_PAGE_LOG2 = 12;
  parameter int unsigned SPG_STRIDE_W  = 16;
  parameter int unsigned SPG_DEG_W     = 4;
  parameter int unsigned SPG_PRIO_W    = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/spg_seq_counter.sv
// Walks the stride multiples: holds the running candidate line and the index.
module spg_seq_counter
  import spg_pkg::*;
#(
  parameter int unsigned LINE_W   = 42,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned DEG_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [LINE_W-1:0]          base_line,
  input  logic signed [STRIDE_W-1:0] stride,
  input  logic [DEG_W-1:0]           degree,
  input  logic                       advance,
  output logic                       busy,
  output logic [LINE_W-1:0]          cand_line
);
  localparam int unsigned EXT_W = LINE_W - STRIDE_W;

  seq_state_e          state_q;
  logic [LINE_W-1:0]   stride_q;
  logic [LINE_W-1:0]   stride_ext;
  logic [DEG_W-1:0]    idx_q;
  logic [DEG_W-1:0]    deg_q;
  logic                last_step;

  assign stride_ext = {{EXT_W{stride[STRIDE_W-1]}}, stride};
  assign last_step  = (idx_q == deg_q);
  assign busy       = (state_q == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      idx_q     <= '0;
      deg_q     <= '0;
      stride_q  <= '0;
      cand_line <= '0;
    end else if (load) begin
      stride_q  <= stride_ext;
      cand_line <= base_line + stride_ext;
      idx_q     <= {{(DEG_W-1){1'b0}}, 1'b1};
      deg_q     <= degree;
      state_q   <= (degree != '0) ? SEQ_RUN : SEQ_IDLE;
    end else if (advance && busy) begin
      cand_line <= cand_line + stride_q;
      idx_q     <= idx_q + 1'b1;
      if (last_step) state_q <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/spg_page_filter.sv
// Compares a candidate line with the page of the trigger and forms its byte address.
module spg_page_filter #(
  parameter int unsigned LINE_W    = 42,
  parameter int unsigned BLK_LOG2  = 6,
  parameter int unsigned PAGE_LOG2 = 12
) (
  input  logic [LINE_W-1:0]                        cand_line,
  input  logic [LINE_W-(PAGE_LOG2-BLK_LOG2)-1:0]   ref_page,
  output logic                                     keep,
  output logic [LINE_W+BLK_LOG2-1:0]               cand_addr
);
  localparam int unsigned IN_PAGE_W = PAGE_LOG2 - BLK_LOG2;

  assign keep      = (cand_line[LINE_W-1:IN_PAGE_W] == ref_page);
  assign cand_addr = {cand_line, {BLK_LOG2{1'b0}}};
endmodule

// File: rtl/spg_out_stage.sv
// Registered valid/ready output holding one candidate.
module spg_out_stage #(
  parameter int unsigned ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              keep,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              slot_free
);
  assign slot_free = !pf_valid || pf_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (step) begin
      pf_valid <= keep;
      if (keep) pf_addr <= addr_in;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stride_pf_gen.sv
module stride_pf_gen
  import spg_pkg::*;
#(
  parameter int unsigned ADDR_W    = SPG_ADDR_W,
  parameter int unsigned BLK_LOG2  = SPG_BLK_LOG2,
  parameter int unsigned PAGE_LOG2 = SPG_PAGE_LOG2,
  parameter int unsigned STRIDE_W  = SPG_STRIDE_W,
  parameter int unsigned DEG_W     = SPG_DEG_W,
  parameter int unsigned PRIO_W    = SPG_PRIO_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          trig_valid,
  output logic                          trig_ready,
  input  logic [ADDR_W-BLK_LOG2-1:0]    trig_line,
  input  logic signed [STRIDE_W-1:0]    trig_stride,
  input  logic [DEG_W-1:0]              trig_degree,
  output logic                          pf_valid,
  input  logic                          pf_ready,
  output logic [ADDR_W-1:0]             pf_addr,
  output logic [PRIO_W-1:0]             pf_prio
);
  localparam int unsigned LINE_W    = ADDR_W - BLK_LOG2;
  localparam int unsigned IN_PAGE_W = PAGE_LOG2 - BLK_LOG2;
  localparam int unsigned PAGE_W    = LINE_W - IN_PAGE_W;

  logic              accept;
  logic              busy;
  logic              slot_free;
  logic              step;
  logic              keep;
  logic [LINE_W-1:0] cand_line;
  logic [ADDR_W-1:0] cand_addr;
  logic [PAGE_W-1:0] page_q;

  assign trig_ready = !busy && !pf_valid;
  assign accept     = trig_valid && trig_ready;
  assign step       = busy && slot_free;
  assign pf_prio    = '0;

  always_ff @(posedge clk) begin
    if (rst)         page_q <= '0;
    else if (accept) page_q <= trig_line[LINE_W-1:IN_PAGE_W];
  end

  spg_seq_counter #(
    .LINE_W   (LINE_W),
    .STRIDE_W (STRIDE_W),
    .DEG_W    (DEG_W)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .base_line (trig_line),
    .stride    (trig_stride),
    .degree    (trig_degree),
    .advance   (step),
    .busy      (busy),
    .cand_line (cand_line)
  );

  spg_page_filter #(
    .LINE_W    (LINE_W),
    .BLK_LOG2  (BLK_LOG2),
    .PAGE_LOG2 (PAGE_LOG2)
  ) i_filter (
    .cand_line (cand_line),
    .ref_page  (page_q),
    .keep      (keep),
    .cand_addr (cand_addr)
  );

  spg_out_stage #(
    .ADDR_W (ADDR_W)
  ) i_out (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .keep      (keep),
    .addr_in   (cand_addr),
    .pf_ready  (pf_ready),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned BLK_LOG2  = 6,
  parameter int unsigned PAGE_LOG2 = 12,
  parameter int unsigned DEG_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       trig_valid,
  input logic                       trig_ready,
  input logic [ADDR_W-BLK_LOG2-1:0] trig_line,
  input logic [DEG_W-1:0]           trig_degree,
  input logic                       pf_valid,
  input logic                       pf_ready,
  input logic [ADDR_W-1:0]          pf_addr
);
  localparam int unsigned LINE_W    = ADDR_W - BLK_LOG2;
  localparam int unsigned IN_PAGE_W = PAGE_LOG2 - BLK_LOG2;

  logic [LINE_W-1:0] line_q;
  logic [DEG_W-1:0]  deg_q;
  logic [DEG_W:0]    sent_q;
  logic              acc;

  assign acc = trig_valid && trig_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      deg_q  <= '0;
      sent_q <= '0;
    end else if (acc) begin
      line_q <= trig_line;
      deg_q  <= trig_degree;
      sent_q <= '0;
    end else if (pf_valid && pf_ready) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pf_valid && trig_ready)); // R9

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (acc && trig_degree != '0) |=> !trig_ready); // R6

  AST_ZERO_DEGREE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (acc && trig_degree == '0) |=> (trig_ready && !pf_valid)); // R8

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[ADDR_W-1:PAGE_LOG2] == (line_q >> IN_PAGE_W))); // R3

  AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready) |-> (sent_q < {1'b0, deg_q})); // R5
endmodule

bind stride_pf_gen spg_checker #(
  .ADDR_W    (ADDR_W),
  .BLK_LOG2  (BLK_LOG2),
  .PAGE_LOG2 (PAGE_LOG2),
  .DEG_W     (DEG_W)
) i_spg_checker (
  .clk         (clk),
  .rst         (rst),
  .trig_valid  (trig_valid),
  .trig_ready  (trig_ready),
  .trig_line   (trig_line),
  .trig_degree (trig_degree),
  .pf_valid    (pf_valid),
  .pf_ready    (pf_ready),
  .pf_addr     (pf_addr)
);

// File: tb/test_stride_pf_gen.sv
`timescale 1ns/1ps
module test_stride_pf_gen;
  localparam int ADDR_W    = 48;
  localparam int BLK_LOG2  = 6;
  localparam int PAGE_LOG2 = 12;
  localparam int STRIDE_W  = 16;
  localparam int DEG_W     = 4;
  localparam int PRIO_W    = 2;
  localparam int LINE_W    = ADDR_W - BLK_LOG2;
  localparam int IN_PAGE_W = PAGE_LOG2 - BLK_LOG2;
  localparam longint LMASK = (64'd1 << LINE_W) - 1;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       trig_valid = 1'b0;
  logic                       trig_ready;
  logic [LINE_W-1:0]          trig_line = '0;
  logic signed [STRIDE_W-1:0] trig_stride = '0;
  logic [DEG_W-1:0]           trig_degree = '0;
  logic                       pf_valid;
  logic                       pf_ready = 1'b1;
  logic [ADDR_W-1:0]          pf_addr;
  logic [PRIO_W-1:0]          pf_prio;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] got_q[$];
  logic [ADDR_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  stride_pf_gen i_stride_pf_gen (
    .clk(clk), .rst(rst),
    .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_line(trig_line), .trig_stride(trig_stride), .trig_degree(trig_degree),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_prio(pf_prio)
  );

  // Monitor: record a transfer, then set ready for the next cycle.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && pf_valid && pf_ready) begin
      got_q.push_back(pf_addr);
      tests++;
      if (pf_prio !== '0) begin
        fails++;
        $display("FAIL R2 priority actual=%0d expected=0", pf_prio);
      end
    end
    pf_ready = stall_mode ? (cyc[0] ^ cyc[2]) : 1'b1;
  end

  function automatic void add_expected(longint base, int stride, int deg);
    for (int d = 1; d <= deg; d++) begin
      longint ln = (base + longint'(stride) * d) & LMASK;
      if ((ln >> IN_PAGE_W) == (base >> IN_PAGE_W))
        exp_q.push_back(ADDR_W'(ln << BLK_LOG2));
    end
  endfunction

  task automatic check(string req, string what, longint act, longint expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic compare_lists(string req);
    check(req, "candidate count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) check(req, "candidate address", got_q[i], exp_q[i]);
  endtask

  // Send one trigger and wait for the run to finish; returns low cycles of trig_ready.
  task automatic run_one(longint base, int stride, int deg, output int lows);
    @(negedge clk);
    while (!trig_ready) @(negedge clk);
    got_q.delete();
    exp_q.delete();
    add_expected(base, stride, deg);
    trig_line   = LINE_W'(base);
    trig_stride = STRIDE_W'(stride);
    trig_degree = DEG_W'(deg);
    trig_valid  = 1'b1;
    @(negedge clk);
    trig_valid  = 1'b0;
    trig_degree = DEG_W'(deg == 1 ? 15 : 1);  // R5: later changes must not matter
    trig_line   = '1;
    lows = 0;
    while (!trig_ready && lows < 1000) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R9", "trig_ready after reset", trig_ready, 1);
    check("R9", "pf_valid after reset", pf_valid, 0);
  endtask

  task automatic t_ascending();
    int lows;
    run_one(64'h0000_4000_0000, 2, 4, lows);
    compare_lists("R1");
    check("R10", "busy cycles, last kept", lows, 5);
  endtask

  task automatic t_descending();
    int lows;
    run_one(64'h0000_0123_400A, -3, 3, lows);
    compare_lists("R4");
    check("R4", "third candidate below first", (got_q.size() == 3 && got_q[2] < got_q[0]), 1);
  endtask

  task automatic t_page_cross();
    int lows;
    run_one(64'h0000_0777_003C, 2, 4, lows);
    compare_lists("R3");
    check("R3", "one candidate kept", got_q.size(), 1);
    check("R10", "busy cycles, last dropped", lows, 4);
  endtask

  task automatic t_all_dropped();
    int lows;
    run_one(64'h0000_0555_0000, 100, 3, lows);
    check("R3", "nothing offered", got_q.size(), 0);
    check("R10", "busy cycles, all dropped", lows, 3);
  endtask

  task automatic t_zero_stride();
    int lows;
    run_one(64'h0000_0999_0011, 0, 2, lows);
    compare_lists("R4");
  endtask

  task automatic t_degree_hold();
    int lows;
    run_one(64'h0000_0321_0000, 1, 5, lows);
    compare_lists("R5");
  endtask

  task automatic t_backpressure();
    int lows;
    stall_mode = 1'b1;
    run_one(64'h0000_0aaa_0000, 1, 6, lows);
    compare_lists("R7");
    stall_mode = 1'b0;
  endtask

  task automatic t_zero_degree();
    int lows;
    run_one(64'h0000_0bbb_0000, 1, 0, lows);
    check("R8", "nothing offered", got_q.size(), 0);
    check("R8", "trig_ready stays high", lows, 0);
  endtask

  task automatic t_max_degree();
    int lows;
    run_one(64'h0000_0ccc_0000, 1, 15, lows);
    compare_lists("R1");
  endtask

  task automatic t_held_trigger();
    int guard;
    @(negedge clk);
    while (!trig_ready) @(negedge clk);
    got_q.delete();
    exp_q.delete();
    add_expected(64'h0000_0ddd_0000, 3, 4);
    add_expected(64'h0000_0eee_0020, -1, 3);
    trig_line = LINE_W'(64'h0000_0ddd_0000); trig_stride = 3; trig_degree = 4;
    trig_valid = 1'b1;
    @(negedge clk);
    trig_line = LINE_W'(64'h0000_0eee_0020); trig_stride = -1; trig_degree = 3;
    guard = 0;
    while (!trig_ready && guard < 1000) begin guard++; @(negedge clk); end
    @(negedge clk);
    trig_valid = 1'b0;
    guard = 0;
    while (!trig_ready && guard < 1000) begin guard++; @(negedge clk); end
    compare_lists("R6");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ascending();
    t_descending();
    t_page_cross();
    t_all_dropped();
    t_zero_stride();
    t_degree_hold();
    t_backpressure();
    t_zero_degree();
    t_max_degree();
    t_held_trigger();
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule